// File: doc/BRIEF.md
# Dual-Port UTOPIA PHY Cell Interface

This block sits between an ATM-layer device and the two cell queues of a modem that carries a fast channel and an interleaved channel. Each channel appears on the UTOPIA bus as its own PHY port with a configurable 5-bit address. The block moves 8-bit cell bytes, marks the first byte of each 53-byte cell, answers cell-available polls, and honours the active-low transfer enables in both directions. All UTOPIA-side logic runs on one clock, which is shared with the queue side.

Two bus modes are available. In single-PHY mode only the fast channel is reachable, the address buses are ignored, and the outputs are driven all the time. In multi-PHY mode a port answers a poll, or takes part in a transfer, only when its own address was placed on the bus. A port whose address is not on the bus leaves its outputs released. Every output has an enable pin for the pad ring. A float control releases all of them at once, and the interface-enable control parks the block when a different line interface owns the pins.

The receive queue side is valid/ready. The block raises `rxq_ready` for at most one queue per cycle, and the head byte is consumed in that cycle. A new cell starts only when that queue flags a whole cell. After that, each later byte of the cell waits on `rxq_valid`. The transmit queue side has no back-pressure wire. Its `txq_space` flag is reported to the ATM layer as cell-available, and bytes pushed after the ATM layer has seen that flag low are not protected.

Top module: `utopia_dual_phy`

## Requirements
- R1: During reset and right after it, every output enable is low, `txq_valid` is 0 and `rxq_ready` is 0.
- R2: When `cfg_tristate` is 1 or `cfg_enable` is 0, every output enable is low in the same cycle, no receive byte is popped, `u_rx_soc` stays 0 and no `txq_valid` pulse is produced.
- R3: In single-PHY mode (`cfg_level2`=0), the address buses are ignored. One cycle after enabling, the data and cell-available enables are high, and receive cell-available follows `rxq_cell[0]`.
- R4: In multi-PHY mode, the receive cell-available output is driven in the cycle after a rising edge where `u_rx_addr` equals a port address. Its value is that port's `rxq_cell` bit. Address 5'h1F, and any address that matches no port, leave the enable low.
- R5: In multi-PHY mode, a port is selected by the address sampled at a rising edge where the enable is high (`enb_n`=1). The selection holds while the enable is low, whatever is then on the address bus. An unmatched address sampled with the enable high deselects the port and drops the data enable.
- R6: Each rising edge with `u_rx_enb_n`=0 and a selected, ready port pops one byte and presents it after that edge. `u_rx_soc` is 1 only with byte 0 of each 53-byte cell.
- R7: At byte 0 a transfer starts only if the port's `rxq_cell` bit is 1. Within a cell it proceeds only if its `rxq_valid` bit is 1. Otherwise nothing is popped and `u_rx_soc` is 0.
- R8: A byte and start marker sampled at a rising edge with `u_tx_enb_n`=0 appear on `txq_data`/`txq_sop` after that edge, with a one-cycle pulse on the selected port's `txq_valid` bit (bit 0 fast, bit 1 interleaved).
- R9: Transmit cell-available reports the `txq_space` bit of the polled port, in the same poll timing as R4 (single-PHY: bit 0).
- R10: When both ports hold the same address, the fast port (index 0) wins both poll and selection.
- R11: Each port keeps its own byte position. A port deselected mid-cell resumes at the next byte, with no start marker, when it is selected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | UTOPIA owns the pins |
| cfg_level2 | input | 1 | 1 multi-PHY, 0 single-PHY |
| cfg_tristate | input | 1 | Release all outputs |
| cfg_port_addr | input | 10 | Port addresses: [4:0] fast, [9:5] interleaved |
| u_rx_addr | input | 5 | Receive address bus |
| u_rx_enb_n | input | 1 | Receive enable, active low |
| u_rx_data | output | 8 | Receive cell byte |
| u_rx_soc | output | 1 | Receive start of cell |
| u_rx_clav | output | 1 | Receive cell available |
| u_rx_data_oe | output | 1 | Drive enable for data and start of cell |
| u_rx_clav_oe | output | 1 | Drive enable for receive cell available |
| u_tx_addr | input | 5 | Transmit address bus |
| u_tx_enb_n | input | 1 | Transmit enable, active low |
| u_tx_data | input | 8 | Transmit cell byte |
| u_tx_soc | input | 1 | Transmit start of cell |
| u_tx_clav | output | 1 | Transmit cell available |
| u_tx_clav_oe | output | 1 | Drive enable for transmit cell available |
| rxq_cell | input | 2 | Queue holds a whole unstarted cell, per port |
| rxq_valid | input | 2 | Queue head byte valid, per port |
| rxq_data | input | 16 | Queue head bytes: [7:0] fast, [15:8] interleaved |
| rxq_ready | output | 2 | Pop strobe, per port |
| txq_space | input | 2 | Room for one whole cell, per port |
| txq_valid | output | 2 | Push strobe, per port |
| txq_data | output | 8 | Pushed byte |
| txq_sop | output | 1 | Pushed byte is a start of cell |

## Verification
Four properties are checked on every cycle: at most one pop or push strobe is high, a start marker follows only a pop from a queue that flagged a whole cell, a push follows only a sampled low enable, and a held selection stays stable while the enable is low. Fast-port priority and the absence of a start marker while the pins float are also checked every cycle. The scenarios show the rest. They cover the exact byte sequence and marker position over whole cells, stalls at a cell boundary and mid-cell, resuming a port's position after switching, the poll answers for matched, unmatched and null addresses, and the same-cycle release of all enables.

// File: rtl/utopia_dual_pkg.sv
package utopia_dual_pkg;
  parameter int BYTE_W     = 8;
  parameter int ADDR_W     = 5;
  parameter int N_PORTS    = 2;
  parameter int CELL_BYTES = 53;

  localparam int CH_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
  localparam int POS_W = $clog2(CELL_BYTES);
  localparam logic [ADDR_W-1:0] NULL_ADDR = '1;

  typedef logic [BYTE_W-1:0] cell_byte_t;
  typedef logic [CH_W-1:0]   port_idx_t;
  typedef logic [POS_W-1:0]  cell_pos_t;
endpackage

// File: rtl/utp_port_sel.sv
module utp_port_sel
  import utopia_dual_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      active,
  input  logic                      level2,
  input  logic [N_PORTS*ADDR_W-1:0] port_addr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      enb_n,
  output logic                      sel_vld,
  output port_idx_t                 sel_idx,
  output logic                      poll_vld,
  output port_idx_t                 poll_idx
);
  logic [N_PORTS-1:0] hit;
  logic               hit_any;
  port_idx_t          hit_idx;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_match
    assign hit[p] = (bus_addr == port_addr[p*ADDR_W +: ADDR_W]) && (bus_addr != NULL_ADDR);
  end

  // lowest index wins when addresses collide
  always_comb begin
    hit_any = |hit;
    hit_idx = '0;
    for (int p = N_PORTS - 1; p >= 0; p--)
      if (hit[p]) hit_idx = CH_W'(p);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_vld  <= 1'b0;
      sel_idx  <= '0;
      poll_vld <= 1'b0;
      poll_idx <= '0;
    end else if (!active) begin
      sel_vld  <= 1'b0;
      poll_vld <= 1'b0;
    end else if (!level2) begin
      sel_vld  <= 1'b1;
      sel_idx  <= '0;
      poll_vld <= 1'b1;
      poll_idx <= '0;
    end else begin
      poll_vld <= hit_any;
      poll_idx <= hit_idx;
      if (enb_n) begin
        sel_vld <= hit_any;
        sel_idx <= hit_idx;
      end
    end
  end

  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && level2 && !enb_n) |=> $stable(sel_idx));

  // R10
  fast_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && level2 && enb_n && hit[0]) |=> (sel_vld && sel_idx == '0));
endmodule

// File: rtl/utp_rx_path.sv
module utp_rx_path
  import utopia_dual_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      active,
  input  logic                      enb_n,
  input  logic                      sel_vld,
  input  port_idx_t                 sel_idx,
  input  logic                      poll_vld,
  input  port_idx_t                 poll_idx,
  input  logic [N_PORTS-1:0]        rxq_cell,
  input  logic [N_PORTS-1:0]        rxq_valid,
  input  logic [N_PORTS*BYTE_W-1:0] rxq_data,
  output logic [N_PORTS-1:0]        rxq_ready,
  output cell_byte_t                rx_data,
  output logic                      rx_soc,
  output logic                      rx_clav,
  output logic                      rx_data_oe,
  output logic                      rx_clav_oe
);
  localparam cell_pos_t LAST_POS = POS_W'(CELL_BYTES - 1);

  cell_pos_t pos_q [N_PORTS];
  logic      at_start;
  logic      can_go;
  logic      go;

  assign at_start = (pos_q[sel_idx] == '0);
  assign can_go   = at_start ? rxq_cell[sel_idx] : rxq_valid[sel_idx];
  assign go       = active && !enb_n && sel_vld && can_go;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_pos
    assign rxq_ready[p] = go && (sel_idx == CH_W'(p));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pos_q[p] <= '0;
      else if (rxq_ready[p]) pos_q[p] <= (pos_q[p] == LAST_POS) ? '0 : pos_q[p] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_soc  <= 1'b0;
    end else begin
      rx_soc <= go && at_start;
      if (go) rx_data <= rxq_data[sel_idx*BYTE_W +: BYTE_W];
    end
  end

  assign rx_clav    = poll_vld && rxq_cell[poll_idx];
  assign rx_clav_oe = active && poll_vld;
  assign rx_data_oe = active && sel_vld;

  // R6
  one_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rxq_ready));

  // R7
  soc_needs_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_soc |-> $past(|(rxq_ready & rxq_cell)));
endmodule

// File: rtl/utp_tx_path.sv
module utp_tx_path
  import utopia_dual_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               enb_n,
  input  logic               sel_vld,
  input  port_idx_t          sel_idx,
  input  logic               poll_vld,
  input  port_idx_t          poll_idx,
  input  cell_byte_t         tx_data,
  input  logic               tx_soc,
  input  logic [N_PORTS-1:0] txq_space,
  output logic [N_PORTS-1:0] txq_valid,
  output cell_byte_t         txq_data,
  output logic               txq_sop,
  output logic               tx_clav,
  output logic               tx_clav_oe
);
  logic go;
  assign go = active && !enb_n && sel_vld;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_push
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) txq_valid[p] <= 1'b0;
      else        txq_valid[p] <= go && (sel_idx == CH_W'(p));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txq_data <= '0;
      txq_sop  <= 1'b0;
    end else if (go) begin
      txq_data <= tx_data;
      txq_sop  <= tx_soc;
    end
  end

  assign tx_clav    = poll_vld && txq_space[poll_idx];
  assign tx_clav_oe = active && poll_vld;

  // R8
  one_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(txq_valid));

  // R8
  push_after_enb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|txq_valid) |-> $past(!enb_n && active));
endmodule

// File: rtl/utopia_dual_phy.sv
module utopia_dual_phy
  import utopia_dual_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_enable,
  input  logic                      cfg_level2,
  input  logic                      cfg_tristate,
  input  logic [N_PORTS*ADDR_W-1:0] cfg_port_addr,
  input  logic [ADDR_W-1:0]         u_rx_addr,
  input  logic                      u_rx_enb_n,
  output logic [BYTE_W-1:0]         u_rx_data,
  output logic                      u_rx_soc,
  output logic                      u_rx_clav,
  output logic                      u_rx_data_oe,
  output logic                      u_rx_clav_oe,
  input  logic [ADDR_W-1:0]         u_tx_addr,
  input  logic                      u_tx_enb_n,
  input  logic [BYTE_W-1:0]         u_tx_data,
  input  logic                      u_tx_soc,
  output logic                      u_tx_clav,
  output logic                      u_tx_clav_oe,
  input  logic [N_PORTS-1:0]        rxq_cell,
  input  logic [N_PORTS-1:0]        rxq_valid,
  input  logic [N_PORTS*BYTE_W-1:0] rxq_data,
  output logic [N_PORTS-1:0]        rxq_ready,
  input  logic [N_PORTS-1:0]        txq_space,
  output logic [N_PORTS-1:0]        txq_valid,
  output logic [BYTE_W-1:0]         txq_data,
  output logic                      txq_sop
);
  logic      active;
  logic      rx_sel_vld, rx_poll_vld, tx_sel_vld, tx_poll_vld;
  port_idx_t rx_sel_idx, rx_poll_idx, tx_sel_idx, tx_poll_idx;

  assign active = cfg_enable && !cfg_tristate;

  utp_port_sel u_rx_sel (
    .clk(clk), .rst_n(rst_n), .active(active), .level2(cfg_level2),
    .port_addr(cfg_port_addr), .bus_addr(u_rx_addr), .enb_n(u_rx_enb_n),
    .sel_vld(rx_sel_vld), .sel_idx(rx_sel_idx),
    .poll_vld(rx_poll_vld), .poll_idx(rx_poll_idx));

  utp_port_sel u_tx_sel (
    .clk(clk), .rst_n(rst_n), .active(active), .level2(cfg_level2),
    .port_addr(cfg_port_addr), .bus_addr(u_tx_addr), .enb_n(u_tx_enb_n),
    .sel_vld(tx_sel_vld), .sel_idx(tx_sel_idx),
    .poll_vld(tx_poll_vld), .poll_idx(tx_poll_idx));

  utp_rx_path u_rx (
    .clk(clk), .rst_n(rst_n), .active(active), .enb_n(u_rx_enb_n),
    .sel_vld(rx_sel_vld), .sel_idx(rx_sel_idx),
    .poll_vld(rx_poll_vld), .poll_idx(rx_poll_idx),
    .rxq_cell(rxq_cell), .rxq_valid(rxq_valid), .rxq_data(rxq_data),
    .rxq_ready(rxq_ready), .rx_data(u_rx_data), .rx_soc(u_rx_soc),
    .rx_clav(u_rx_clav), .rx_data_oe(u_rx_data_oe), .rx_clav_oe(u_rx_clav_oe));

  utp_tx_path u_tx (
    .clk(clk), .rst_n(rst_n), .active(active), .enb_n(u_tx_enb_n),
    .sel_vld(tx_sel_vld), .sel_idx(tx_sel_idx),
    .poll_vld(tx_poll_vld), .poll_idx(tx_poll_idx),
    .tx_data(u_tx_data), .tx_soc(u_tx_soc), .txq_space(txq_space),
    .txq_valid(txq_valid), .txq_data(txq_data), .txq_sop(txq_sop),
    .tx_clav(u_tx_clav), .tx_clav_oe(u_tx_clav_oe));

  // R2
  no_soc_while_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_tristate) && cfg_tristate) |-> !u_rx_soc);
endmodule

// File: tb/utopia_dual_phy_test.sv
module utopia_dual_phy_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_enable = 0, cfg_level2 = 0, cfg_tristate = 0;
  logic [9:0]  cfg_port_addr = '0;
  logic [4:0]  u_rx_addr = '0, u_tx_addr = '0;
  logic        u_rx_enb_n = 1, u_tx_enb_n = 1;
  logic [7:0]  u_rx_data;
  logic        u_rx_soc, u_rx_clav, u_rx_data_oe, u_rx_clav_oe;
  logic [7:0]  u_tx_data = '0;
  logic        u_tx_soc = 0;
  logic        u_tx_clav, u_tx_clav_oe;
  logic [1:0]  rxq_cell = '0, rxq_valid = 2'b11, rxq_ready;
  logic [15:0] rxq_data;
  logic [1:0]  txq_space = '0, txq_valid;
  logic [7:0]  txq_data;
  logic        txq_sop;
  logic [7:0]  pop_cnt [2];
  int          n_total = 0, n_fail = 0;

  always #10 clk = ~clk;

  initial begin pop_cnt[0] = 0; pop_cnt[1] = 0; end
  always @(posedge clk)
    for (int c = 0; c < 2; c++) if (rxq_ready[c]) pop_cnt[c] <= pop_cnt[c] + 8'd1;
  assign rxq_data = {1'b1, pop_cnt[1][6:0], 1'b0, pop_cnt[0][6:0]};

  utopia_dual_phy uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic rx_burst(input int ch, input int n, input int pos0, input string tag);
    logic [7:0] base;
    logic [7:0] expb;
    base = pop_cnt[ch];
    u_rx_enb_n = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      expb = {ch[0], 7'(base + 8'(i))};
      check(tag, {23'd0, u_rx_soc, u_rx_data}, {23'd0, ((pos0 + i) == 0), expb});
    end
    check({tag, " count"}, 32'(pop_cnt[ch] - base), 32'(n));
    u_rx_enb_n = 1;
  endtask

  task automatic t_reset();
    check("R1 oe", {u_rx_data_oe, u_rx_clav_oe, u_tx_clav_oe}, 0);
    check("R1 push/pop", {txq_valid, rxq_ready}, 0);
  endtask

  task automatic t_level1_rx();
    logic [7:0] b;
    cfg_enable = 1; cfg_level2 = 0; rxq_cell = 2'b01; u_rx_addr = 5'h07;
    tick();
    check("R3 enables", {u_rx_data_oe, u_rx_clav_oe, u_rx_clav}, 3'b111);
    rxq_cell = 2'b00; #1;
    check("R3 clav low", u_rx_clav, 0);
    rxq_cell = 2'b01;
    rx_burst(0, 53, 0, "R6 cell");
    rxq_cell = 2'b00; b = pop_cnt[0]; u_rx_enb_n = 0;
    tick(); tick();
    check("R7 no cell soc", u_rx_soc, 0);
    check("R7 no cell pop", pop_cnt[0], b);
    u_rx_enb_n = 1; rxq_cell = 2'b01;
    rx_burst(0, 3, 0, "R7 head");
    rxq_valid = 2'b10; b = pop_cnt[0]; u_rx_enb_n = 0;
    tick(); tick();
    check("R7 stall pop", pop_cnt[0], b);
    check("R7 stall soc", u_rx_soc, 0);
    rxq_valid = 2'b11;
    rx_burst(0, 50, 3, "R7 rest");
  endtask

  task automatic t_level1_tx();
    txq_space = 2'b01; tick();
    check("R9 l1 clav", {u_tx_clav_oe, u_tx_clav}, 2'b11);
    u_tx_enb_n = 0; u_tx_data = 8'hA5; u_tx_soc = 1;
    tick();
    check("R8 push", {txq_valid, txq_sop, txq_data}, {2'b01, 1'b1, 8'hA5});
    u_tx_enb_n = 1; u_tx_soc = 0;
    tick();
    check("R8 pulse", txq_valid, 0);
  endtask

  task automatic t_level2_poll();
    cfg_level2 = 1; cfg_port_addr = {5'd9, 5'd3}; rxq_cell = 2'b10; txq_space = 2'b01;
    u_rx_addr = 5'd3; u_tx_addr = 5'd9; tick();
    check("R4 fast", {u_rx_clav_oe, u_rx_clav}, 2'b10);
    check("R9 intl", {u_tx_clav_oe, u_tx_clav}, 2'b10);
    u_rx_addr = 5'd9; u_tx_addr = 5'd3; tick();
    check("R4 intl", {u_rx_clav_oe, u_rx_clav}, 2'b11);
    check("R9 fast", {u_tx_clav_oe, u_tx_clav}, 2'b11);
    u_rx_addr = 5'h1F; u_tx_addr = 5'd5; tick();
    check("R4 null", u_rx_clav_oe, 0);
    check("R4 miss", u_tx_clav_oe, 0);
    cfg_port_addr = {5'd9, 5'h1F}; u_rx_addr = 5'h1F; tick();
    check("R4 null cfg", u_rx_clav_oe, 0);
    cfg_port_addr = {5'd9, 5'd3};
  endtask

  task automatic t_level2_rx();
    u_rx_addr = 5'd9; tick();
    check("R5 selected", u_rx_data_oe, 1);
    u_rx_addr = 5'd3;
    rx_burst(1, 53, 0, "R5 hold");
    u_rx_addr = 5'd4; tick();
    check("R5 deselect", u_rx_data_oe, 0);
  endtask

  task automatic t_switch();
    rxq_cell = 2'b11;
    u_rx_addr = 5'd3; tick();
    rx_burst(0, 10, 0, "R11 fast a");
    u_rx_addr = 5'd9; tick();
    rx_burst(1, 53, 0, "R11 intl");
    u_rx_addr = 5'd3; tick();
    rx_burst(0, 43, 10, "R11 fast b");
  endtask

  task automatic t_priority();
    cfg_port_addr = {5'd6, 5'd6}; rxq_cell = 2'b10;
    u_tx_addr = 5'd6; u_rx_addr = 5'd6; tick();
    check("R10 poll", {u_rx_clav_oe, u_rx_clav}, 2'b10);
    u_tx_enb_n = 0; u_tx_data = 8'h3C; u_tx_soc = 0; tick();
    check("R10 push", {txq_valid, txq_sop, txq_data}, {2'b01, 1'b0, 8'h3C});
    u_tx_enb_n = 1; cfg_port_addr = {5'd12, 5'd6}; u_tx_addr = 5'd12; tick();
    u_tx_enb_n = 0; u_tx_data = 8'h5A; u_tx_soc = 1; tick();
    check("R8 intl push", {txq_valid, txq_sop, txq_data}, {2'b10, 1'b1, 8'h5A});
    u_tx_enb_n = 1; u_tx_soc = 0; tick();
  endtask

  task automatic t_float();
    logic [7:0] b0, b1;
    cfg_port_addr = {5'd9, 5'd3}; rxq_cell = 2'b11;
    u_rx_addr = 5'd3; u_tx_addr = 5'd3; tick();
    check("R2 pre", u_rx_data_oe, 1);
    for (int m = 0; m < 2; m++) begin
      if (m == 0) cfg_tristate = 1; else begin cfg_tristate = 0; cfg_enable = 0; end
      #1;
      check("R2 oe now", {u_rx_data_oe, u_rx_clav_oe, u_tx_clav_oe}, 0);
      b0 = pop_cnt[0]; b1 = pop_cnt[1];
      u_rx_enb_n = 0; u_tx_enb_n = 0; u_tx_data = 8'h11;
      tick(); tick();
      check("R2 pops", {pop_cnt[1], pop_cnt[0]}, {b1, b0});
      check("R2 soc/push", {u_rx_soc, txq_valid}, 0);
      u_rx_enb_n = 1; u_tx_enb_n = 1;
    end
    cfg_enable = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    t_reset();
    t_level1_rx();
    t_level1_tx();
    t_level2_poll();
    t_level2_rx();
    t_switch();
    t_priority();
    t_float();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule